// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a CPU address bus and memory. It turns logical addresses in the low RAM zone into physical addresses by looking up a map table of 1024 sixteen-bit entries, one per 4 KiB page. Each entry gives a physical page number and carries a two-bit page status. Every translated access updates that status as a side effect: the first read marks a page as read, any write marks it dirty, and the write-enable bit and the physical page number are left alone. Addresses at or above the RAM zone bypass the table unchanged.

An access is one cycle with a strobe. The translated address and the not-present flag are valid combinationally in that same cycle. A status change is held in a one-entry write-back stage and reaches the table at the following clock edge. Until then, translation and host reads of that entry see the held value. A host port loads and reads the table one byte at a time. A host write to an entry's status byte overrides any status write-back for that entry that has not yet been committed.

Top module: `pgx_xlat`

## Requirements
- R1: An access whose address has any bit at or above bit 22 set (address >= 0x400000) produces `phys_addr` equal to `acc_addr`, never raises `page_absent`, and changes no table entry.
- R2: For an address below 0x400000, the page index is `acc_addr[21:12]` and `phys_addr` is the zero-extended value of {entry[9:0], acc_addr[11:0]}, where entry[9:0] is the physical page.
- R3: The status is entry bits [14:13], encoded 0 = absent, 1 = present and untouched, 2 = read, 3 = dirty. A translated read of a status-1 page sets it to 2, and a translated write sets it to 3.
- R4: A translated write of a status-2 or status-3 page sets it to 3. A translated read of such a page leaves it unchanged.
- R5: A status update leaves entry bit 15 (write enable), bits [12:0] and the whole low byte unchanged.
- R6: A strobed access to a status-0 page raises `page_absent` in that cycle and leaves the entry unchanged. `page_absent` is low whenever `acc_valid` is low.
- R7: The host port is byte-addressed with two bytes per entry. Even `host_addr` selects entry bits [15:8] of entry `host_addr[10:1]`, and odd selects bits [7:0]. `host_rdata` shows the addressed byte in the same cycle, and a host write takes effect at the clock edge.
- R8: A status update is visible to a strobed access or a host read in the cycle right after the strobe, before it is committed to the table.
- R9: A host write to an entry's high byte cancels any status write-back for that entry that has not yet been committed, whether the strobe is in the same cycle or the previous one. The host's byte is the value that remains.
- R10: While reset is held and just after it, no write-back is pending and `page_absent` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the write-back stage |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 24 | Logical address |
| phys_addr | output | 24 | Translated or passed-through address |
| page_absent | output | 1 | Strobed access hit a status-0 page |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | 11 | Host byte address into the table |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for `host_addr` |

## Verification
The bench loads entries at the page and offset extremes and drives reads and writes against every status value. A design that updated the status without masking would clear the write-enable bit. A translation that touched absent pages would mark them present. A write followed at once by a read to the same page only ends dirty when the held write-back is forwarded. Without forwarding, the read would work from the stale status-1 value and downgrade the page to read. Host writes to the status byte, placed in the strobe cycle and in the cycle after it, show whether a late write-back is allowed to overwrite freshly loaded table contents.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_FRESH  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_status_e;

  // Status field sits at bits [6:5] of the high byte (entry bits [14:13]).
  localparam int ST_LSB = 5;

  function automatic logic [1:0] status_of(input logic [7:0] hi);
    return hi[ST_LSB+1:ST_LSB];
  endfunction

  function automatic logic [1:0] status_next(input logic [1:0] cur, input logic wr);
    logic [1:0] nxt;
    case (cur)
      PG_FRESH:          nxt = wr ? PG_DIRTY : PG_READ;
      PG_READ, PG_DIRTY: nxt = wr ? PG_DIRTY : cur;
      default:           nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic [7:0] status_patch(input logic [7:0] hi, input logic [1:0] st);
    logic [7:0] o;
    o = hi;
    o[ST_LSB+1:ST_LSB] = st;
    return o;
  endfunction

endpackage

// File: rtl/pgx_map_ram.sv
module pgx_map_ram #(
  parameter int ENTRIES = 1024,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_hi,
  output logic [7:0]       rd_lo,
  input  logic             host_we,
  input  logic             host_lane_hi,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rd_hi,
  output logic [7:0]       host_rd_lo,
  input  logic             wb_we,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [7:0]       wb_hi
);

  logic [7:0] lane_rd   [2];
  logic [7:0] lane_host [2];

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [7:0] cells [ENTRIES];
    logic       host_hit;
    assign host_hit = host_we && (host_lane_hi == (ln == 1));

    if (ln == 1) begin : g_hi
      // Write-back first, host second: the host wins on the same entry.
      always_ff @(posedge clk) begin
        if (wb_we)    cells[wb_idx]   <= wb_hi;
        if (host_hit) cells[host_idx] <= host_wdata;
      end

      assert_host_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_hit && wb_we && host_idx == wb_idx)
        |=> cells[$past(host_idx)] == $past(host_wdata));
    end else begin : g_lo
      always_ff @(posedge clk) begin
        if (host_hit) cells[host_idx] <= host_wdata;
      end
    end

    assign lane_rd[ln]   = cells[rd_idx];
    assign lane_host[ln] = cells[host_idx];
  end

  assign rd_hi      = lane_rd[1];
  assign rd_lo      = lane_rd[0];
  assign host_rd_hi = lane_host[1];
  assign host_rd_lo = lane_host[0];

endmodule

// File: rtl/pgx_status_upd.sv
module pgx_status_upd
  import pgx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       in_zone,
  input  logic [7:0] cur_hi,
  output logic       absent,
  output logic       wb_need,
  output logic [7:0] wb_hi
);

  logic [1:0] cur_st;
  logic [1:0] nxt_st;
  logic       mapped_acc;

  assign cur_st     = status_of(cur_hi);
  assign nxt_st     = status_next(cur_st, acc_write);
  assign mapped_acc = acc_valid && in_zone;
  assign absent     = mapped_acc && (cur_st == PG_ABSENT);
  assign wb_need    = mapped_acc && (nxt_st != cur_st);
  assign wb_hi      = status_patch(cur_hi, nxt_st);

  assert_keep_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_need |-> (wb_hi[7] == cur_hi[7] && wb_hi[4:0] == cur_hi[4:0]));

  assert_no_revive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    absent |-> !wb_need);

endmodule

// File: rtl/pgx_xlat.sv
module pgx_xlat
  import pgx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 10,
  parameter int OFF_W  = 12,
  localparam int ZONE_W  = PAGE_W + OFF_W,
  localparam int ENTRIES = 1 << PAGE_W,
  localparam int HOST_AW = PAGE_W + 1,
  localparam int HI_PG_W = PAGE_W - 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic [ADDR_W-1:0]  phys_addr,
  output logic               page_absent,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata
);

  logic              in_zone;
  logic [PAGE_W-1:0] page;
  logic [7:0]        rd_hi, rd_lo, eff_hi;
  logic [7:0]        host_rd_hi, host_rd_lo;
  logic [PAGE_W-1:0] host_idx;
  logic              host_lane_hi;
  logic              wb_need, cancel_cap;
  logic [7:0]        wb_hi;
  logic              pend_v;
  logic [PAGE_W-1:0] pend_idx;
  logic [7:0]        pend_hi;
  logic [ADDR_W-1:0] xl_addr;

  assign in_zone      = (acc_addr[ADDR_W-1:ZONE_W] == '0);
  assign page         = acc_addr[ZONE_W-1:OFF_W];
  assign host_idx     = host_addr[HOST_AW-1:1];
  assign host_lane_hi = ~host_addr[0];

  pgx_map_ram #(.ENTRIES(ENTRIES)) u_ram (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_idx       (page),
    .rd_hi        (rd_hi),
    .rd_lo        (rd_lo),
    .host_we      (host_we),
    .host_lane_hi (host_lane_hi),
    .host_idx     (host_idx),
    .host_wdata   (host_wdata),
    .host_rd_hi   (host_rd_hi),
    .host_rd_lo   (host_rd_lo),
    .wb_we        (pend_v),
    .wb_idx       (pend_idx),
    .wb_hi        (pend_hi)
  );

  // Forward the held write-back ahead of the table contents.
  assign eff_hi = (pend_v && pend_idx == page) ? pend_hi : rd_hi;

  pgx_status_upd u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .in_zone   (in_zone),
    .cur_hi    (eff_hi),
    .absent    (page_absent),
    .wb_need   (wb_need),
    .wb_hi     (wb_hi)
  );

  always_comb begin
    xl_addr = '0;
    xl_addr[ZONE_W-1:0] = {eff_hi[HI_PG_W-1:0], rd_lo, acc_addr[OFF_W-1:0]};
  end

  assign phys_addr = in_zone ? xl_addr : acc_addr;

  assign cancel_cap = host_we && host_lane_hi && (host_idx == page);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_idx <= '0;
      pend_hi  <= '0;
    end else begin
      pend_v   <= wb_need && !cancel_cap;
      pend_idx <= page;
      pend_hi  <= wb_hi;
    end
  end

  assign host_rdata = host_lane_hi
                    ? ((pend_v && pend_idx == host_idx) ? pend_hi : host_rd_hi)
                    : host_rd_lo;

  assert_bypass_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !in_zone) |=> !pend_v);

  assert_wb_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> (status_of(pend_hi) == PG_READ || status_of(pend_hi) == PG_DIRTY));

  assert_absent_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    page_absent |-> acc_valid);

  assert_wb_from_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> $past(acc_valid));

  assert_wb_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && host_we && host_lane_hi && host_idx == page) |=> !pend_v);

endmodule

// File: tb/pgx_xlat_bench.sv
module pgx_xlat_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [23:0] phys_addr;
  logic        page_absent;
  logic        host_we = 1'b0;
  logic [10:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pgx_xlat u_pgx_xlat (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .phys_addr(phys_addr), .page_absent(page_absent),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  // {hi_init, lo_init, wr, addr, exp_phys, exp_absent, exp_hi_after}
  localparam logic [73:0] VEC [9] = '{
    {8'h20, 8'h55, 1'b0, 24'h001123, 24'h055123, 1'b0, 8'h40},
    {8'h23, 8'hFF, 1'b1, 24'h3FFFFF, 24'h3FFFFF, 1'b0, 8'h63},
    {8'hC1, 8'h00, 1'b0, 24'h200000, 24'h100000, 1'b0, 8'hC1},
    {8'h41, 8'h10, 1'b1, 24'h155ABC, 24'h110ABC, 1'b0, 8'h61},
    {8'hE2, 8'h34, 1'b0, 24'h0AA001, 24'h234001, 1'b0, 8'hE2},
    {8'h9F, 8'h77, 1'b1, 24'h010040, 24'h377040, 1'b1, 8'h9F},
    {8'h20, 8'h02, 1'b0, 24'h000000, 24'h002000, 1'b0, 8'h40},
    {8'h20, 8'h00, 1'b1, 24'h400000, 24'h400000, 1'b0, 8'h20},
    {8'h20, 8'h00, 1'b0, 24'hFFFFFF, 24'hFFFFFF, 1'b0, 8'h20}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic load(input logic [9:0] pg, input logic [7:0] hi, input logic [7:0] lo);
    host_wr({pg, 1'b0}, hi);
    host_wr({pg, 1'b1}, lo);
  endtask

  initial begin : main
    logic [7:0] rb;
    logic [9:0] pg;
    // R10: reset state
    repeat (3) @(negedge clk);
    #1 chk("R10 absent in reset", {31'b0, page_absent}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R10 absent after reset", {31'b0, page_absent}, 32'h0);

    // Vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      pg = VEC[i][54:45];
      load(pg, VEC[i][73:66], VEC[i][65:58]);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = VEC[i][57]; acc_addr = VEC[i][56:33];
      #1;
      chk($sformatf("R2 R1 vec%0d phys", i), {8'h0, phys_addr}, {8'h0, VEC[i][32:9]});
      chk($sformatf("R6 vec%0d absent", i), {31'b0, page_absent}, {31'b0, VEC[i][8]});
      @(negedge clk);
      acc_valid = 1'b0;
      repeat (2) @(negedge clk);
      host_rd({pg, 1'b0}, rb);
      chk($sformatf("R3 R4 R5 vec%0d status byte", i), {24'h0, rb}, {24'h0, VEC[i][7:0]});
      host_rd({pg, 1'b1}, rb);
      chk($sformatf("R5 vec%0d low byte", i), {24'h0, rb}, {24'h0, VEC[i][65:58]});
    end

    // R7: byte order of host port
    load(10'h005, 8'hAB, 8'hCD);
    host_rd(11'h00A, rb);
    chk("R7 even byte", {24'h0, rb}, 32'hAB);
    host_rd(11'h00B, rb);
    chk("R7 odd byte", {24'h0, rb}, 32'hCD);
    @(negedge clk);
    acc_addr = 24'h005777;
    #1 chk("R7 phys from bytes", {8'h0, phys_addr}, 32'h3CD777);
    chk("R6 absent low when idle", {31'b0, page_absent}, 32'h0);

    // R8: write then read of a fresh page back to back
    load(10'h007, 8'h21, 8'h00);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 24'h007010;
    @(negedge clk);
    acc_write = 1'b0; acc_addr = 24'h007020;
    #1 chk("R8 phys second access", {8'h0, phys_addr}, 32'h100020);
    @(negedge clk);
    acc_valid = 1'b0; host_addr = 11'h00E;
    #1 chk("R8 forwarded status", {24'h0, host_rdata}, 32'h61);
    repeat (3) @(negedge clk);
    host_rd(11'h00E, rb);
    chk("R8 committed status", {24'h0, rb}, 32'h61);

    // R8: host read in the cycle right after the strobe
    load(10'h009, 8'h20, 8'h00);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 24'h009000;
    @(negedge clk);
    acc_valid = 1'b0; host_addr = 11'h012;
    #1 chk("R8 host sees held update", {24'h0, host_rdata}, 32'h40);

    // R9: host write in the cycle after the strobe
    load(10'h00C, 8'h20, 8'h00);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 24'h00C000;
    @(negedge clk);
    acc_valid = 1'b0;
    host_we = 1'b1; host_addr = 11'h018; host_wdata = 8'hA2;
    @(negedge clk);
    host_we = 1'b0;
    #1 chk("R9 host byte kept (late)", {24'h0, host_rdata}, 32'hA2);
    repeat (3) @(negedge clk);
    host_rd(11'h018, rb);
    chk("R9 host byte stays (late)", {24'h0, rb}, 32'hA2);

    // R9: host write in the strobe cycle
    load(10'h00D, 8'h20, 8'h00);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 24'h00D000;
    host_we = 1'b1; host_addr = 11'h01A; host_wdata = 8'hC0;
    @(negedge clk);
    acc_valid = 1'b0; host_we = 1'b0;
    repeat (3) @(negedge clk);
    host_rd(11'h01A, rb);
    chk("R9 host byte stays (same cycle)", {24'h0, rb}, 32'hC0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule